// File: doc/BRIEF.md
# Fuse Mirror Register Controller

The block fronts a one-time-programmable fuse array with a bank of shadow (mirror) registers behind a simple 32-bit register port. Software stages the values it wants burned in the mirrors, then writes a command that walks the array one word at a time and burns each word from its mirror. A second command copies the committed fuse contents back into the mirrors. Fuse cells are modelled as a flop array. Each word burn takes a parameterised number of cycles. A per-bit stuck-at-0 mask input lets a test stand in for defective cells.

Fuse bits only move from 0 to 1. Three things gate changes to the array: a sticky write-protect fuse, a software write-disable with a lock, and a busy-guarded command register that carries an error flag. A read-only status word reports Hamming syndromes computed over two committed fields: the two-word debug-response field and the eight-word master-key field.

Top module: `fuse_mirror_ctrl`

## Requirements
- R1: After synchronous reset, every mirror and fuse word, the control register, the command register, the status register and `rdata` are all zero. Reset models a blank array.
- R2: A read with `rd_en` high returns its value on `rdata` at the next clock edge. With `rd_en` low, `rdata` is zero the cycle after. Offsets outside the map, such as 0x218 to 0x230, read zero. The mirror map is: 0x200 and 0x204 system words; 0x208 and 0x20C challenge; 0x210 and 0x214 response; 0x234 to 0x250 key words 0 to 7; 0x254 to 0x270 hash; 0x274 to 0x284 five ID words. Word index 0 to 26 follows that address order.
- R3: A mirror write stores the committed fuse word OR the written data, so it can never clear a programmed bit. Reading a mirror offset returns the mirror.
- R4: Writing bit 1 of the command register (0x20) starts programming. Command bit 1 then reads 1 for 27 x BURN_CYCLES cycles. Word w is burned as fuse OR (mirror AND NOT stuck_mask) at the end of its slot, and bit 1 then clears.
- R5: Writing bit 0 alone starts a read-back. Command bit 0 reads 1 while the 27 mirrors are reloaded from the fuses, one word per cycle. If bits 0 and 1 are both written, programming is started.
- R6: While either operation runs, command writes and mirror writes are ignored.
- R7: Command bit 8 is the error flag. Accepting a command clears it. It is set if any burned word differs from its mirror.
- R8: Once bit 0 of fuse word 0 (write protect) is blown, a program command does not start. It sets bit 8 at once, and the fuses stay unchanged.
- R9: Control register 0x28: bit 31 is write-disable and blocks mirror writes; bit 30 is the lock. Both read back in place.
- R10: Once the lock is set, writes to the control register are ignored until reset.
- R11: Status register 0x24: bits 5:0 hold the XOR of the positions of set bits in the response field (word 0x210 holds positions 0 to 31, word 0x214 holds 32 to 63), and bit 6 holds their parity. Bits 17:10 hold the XOR of the positions of set key bits (key word k holds positions 32k to 32k+31), and bit 18 holds their parity. All other bits are zero. The status is computed from the fuses.
- R12: No fuse bit ever returns from 1 to 0 outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| stuck_mask | input | 32 | Cells that cannot be burned (stuck at 0), applied to every word |
| rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with BURN_CYCLES set to 3, so a full program pass lasts 81 cycles. This lets several complete burns, read-backs, a rejected write-protected program and the lock sequence all fit in one short run. With a burn slot of more than one cycle, the per-word counter is exercised, which catches slot-length and word-stepping errors. The short pass also lets the every-clock model comparison cover the whole busy window, including the commands and mirror writes that arrive during it.

// File: rtl/fmc_pkg.sv
`timescale 1ns/1ps
package fmc_pkg;
  localparam int WORD_W     = 32;
  localparam int NWORDS     = 27;
  localparam int IDXW       = $clog2(NWORDS);

  // register offsets
  localparam logic [11:0] OFF_CMD   = 12'h020;
  localparam logic [11:0] OFF_STAT  = 12'h024;
  localparam logic [11:0] OFF_CTL   = 12'h028;
  localparam logic [11:0] LOW_BASE  = 12'h200;
  localparam int          LOW_WORDS = 6;
  localparam logic [11:0] HIGH_BASE = 12'h234;
  localparam int          HIGH_WORDS = NWORDS - LOW_WORDS;

  // field positions
  localparam int CMD_READ_BIT = 0;
  localparam int CMD_PROG_BIT = 1;
  localparam int CMD_ERR_BIT  = 8;
  localparam int CTL_WD_BIT   = 31;
  localparam int CTL_LOCK_BIT = 30;
  localparam int WP_BIT       = 0;

  // word groups feeding the syndrome units
  localparam int RESP_IDX   = 4;
  localparam int RESP_WORDS = 2;
  localparam int KEY_IDX    = 6;
  localparam int KEY_WORDS  = 8;
  localparam int RESP_BITS  = RESP_WORDS * WORD_W;
  localparam int KEY_BITS   = KEY_WORDS * WORD_W;
  localparam int KEY_STAT_LSB = 10;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PROG = 2'd1,
    SEQ_READ = 2'd2
  } seq_state_e;
endpackage

// File: rtl/fmc_addr_dec.sv
`timescale 1ns/1ps
module fmc_addr_dec
  import fmc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_cmd,
  output logic              is_stat,
  output logic              is_ctl,
  output logic              is_fuse,
  output logic [IDXW-1:0]   fidx
);
  localparam logic [ADDR_W-1:0] LOW_END  = ADDR_W'(LOW_BASE)  + ADDR_W'(4 * LOW_WORDS);
  localparam logic [ADDR_W-1:0] HIGH_END = ADDR_W'(HIGH_BASE) + ADDR_W'(4 * HIGH_WORDS);

  logic lo_hit, hi_hit;

  always_comb begin
    is_cmd  = (addr == ADDR_W'(OFF_CMD));
    is_stat = (addr == ADDR_W'(OFF_STAT));
    is_ctl  = (addr == ADDR_W'(OFF_CTL));
    lo_hit  = (addr >= ADDR_W'(LOW_BASE))  && (addr < LOW_END)  && (addr[1:0] == 2'b00);
    hi_hit  = (addr >= ADDR_W'(HIGH_BASE)) && (addr < HIGH_END) && (addr[1:0] == 2'b00);
    is_fuse = lo_hit || hi_hit;
    if (lo_hit)
      fidx = IDXW'((addr - ADDR_W'(LOW_BASE)) >> 2);
    else
      fidx = IDXW'(LOW_WORDS) + IDXW'((addr - ADDR_W'(HIGH_BASE)) >> 2);
  end
endmodule

// File: rtl/fmc_syndrome.sv
`timescale 1ns/1ps
module fmc_syndrome #(
  parameter int NBITS = 64,
  localparam int IW   = $clog2(NBITS)
) (
  input  logic [NBITS-1:0] bits,
  output logic [IW:0]      syn
);
  logic [IW-1:0] pos_x;
  logic          par;

  always_comb begin
    pos_x = '0;
    par   = 1'b0;
    for (int i = 0; i < NBITS; i++) begin
      if (bits[i]) begin
        pos_x = pos_x ^ IW'(i);
        par   = ~par;
      end
    end
    syn = {par, pos_x};
  end
endmodule

// File: rtl/fmc_seq.sv
`timescale 1ns/1ps
module fmc_seq
  import fmc_pkg::*;
#(
  parameter int BURN_CYCLES = 4,
  parameter int NW          = NWORDS,
  localparam int WW         = $clog2(NW),
  localparam int CW         = (BURN_CYCLES > 1) ? $clog2(BURN_CYCLES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_prog,
  input  logic          start_read,
  output logic          busy_prog,
  output logic          busy_read,
  output logic          burn_en,
  output logic          load_en,
  output logic [WW-1:0] widx
);
  localparam logic [CW-1:0] CYC_LAST  = CW'(BURN_CYCLES - 1);
  localparam logic [WW-1:0] WORD_LAST = WW'(NW - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cyc_q;
  logic [WW-1:0] widx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cyc_q   <= '0;
      widx_q  <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          cyc_q  <= '0;
          widx_q <= '0;
          if (start_prog)      state_q <= SEQ_PROG;
          else if (start_read) state_q <= SEQ_READ;
        end
        SEQ_PROG: begin
          if (cyc_q == CYC_LAST) begin
            cyc_q <= '0;
            if (widx_q == WORD_LAST) state_q <= SEQ_IDLE;
            else                     widx_q  <= widx_q + 1'b1;
          end else begin
            cyc_q <= cyc_q + 1'b1;
          end
        end
        SEQ_READ: begin
          if (widx_q == WORD_LAST) state_q <= SEQ_IDLE;
          else                     widx_q  <= widx_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_prog = (state_q == SEQ_PROG);
  assign busy_read = (state_q == SEQ_READ);
  assign burn_en   = busy_prog && (cyc_q == CYC_LAST);
  assign load_en   = busy_read;
  assign widx      = widx_q;
endmodule

// File: rtl/fuse_mirror_ctrl.sv
`timescale 1ns/1ps
module fuse_mirror_ctrl
  import fmc_pkg::*;
#(
  parameter int BURN_CYCLES = 4,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] stuck_mask,
  output logic [WORD_W-1:0] rdata
);
  localparam int RSW = $clog2(RESP_BITS) + 1;
  localparam int KSW = $clog2(KEY_BITS) + 1;

  logic [WORD_W-1:0] fuse_q   [NWORDS];
  logic [WORD_W-1:0] mirror_q [NWORDS];

  logic            is_cmd, is_stat, is_ctl, is_fuse;
  logic [IDXW-1:0] fidx, widx;
  logic            busy_prog, busy_read, burn_en, load_en;
  logic            err_q, wd_q, lock_q;
  logic            busy, wp_blown, cmd_wr, start_prog, start_read, prog_reject, mir_wr;
  logic [WORD_W-1:0] burn_word, status, rd_val;
  logic [RESP_BITS-1:0] resp_bits;
  logic [KEY_BITS-1:0]  key_bits;
  logic [RSW-1:0] resp_syn;
  logic [KSW-1:0] key_syn;

  fmc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .is_cmd(is_cmd), .is_stat(is_stat), .is_ctl(is_ctl),
    .is_fuse(is_fuse), .fidx(fidx)
  );

  fmc_seq #(.BURN_CYCLES(BURN_CYCLES), .NW(NWORDS)) u_seq (
    .clk(clk), .rst(rst), .start_prog(start_prog), .start_read(start_read),
    .busy_prog(busy_prog), .busy_read(busy_read), .burn_en(burn_en),
    .load_en(load_en), .widx(widx)
  );

  // command acceptance
  assign busy        = busy_prog | busy_read;
  assign wp_blown    = fuse_q[0][WP_BIT];
  assign cmd_wr      = wr_en && is_cmd && !busy;
  assign start_prog  = cmd_wr && wdata[CMD_PROG_BIT] && !wp_blown;
  assign prog_reject = cmd_wr && wdata[CMD_PROG_BIT] && wp_blown;
  assign start_read  = cmd_wr && !wdata[CMD_PROG_BIT] && wdata[CMD_READ_BIT];
  assign mir_wr      = wr_en && is_fuse && !busy && !wd_q;
  assign burn_word   = fuse_q[widx] | (mirror_q[widx] & ~stuck_mask);

  // fuse cells and mirrors
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) begin
        fuse_q[i]   <= '0;
        mirror_q[i] <= '0;
      end
    end else begin
      if (burn_en) fuse_q[widx]   <= burn_word;
      if (load_en) mirror_q[widx] <= fuse_q[widx];
      if (mir_wr)  mirror_q[fidx] <= fuse_q[fidx] | wdata;
    end
  end

  // error flag
  always_ff @(posedge clk) begin
    if (rst)                                       err_q <= 1'b0;
    else if (start_prog || start_read)             err_q <= 1'b0;
    else if (prog_reject)                          err_q <= 1'b1;
    else if (burn_en && (burn_word != mirror_q[widx])) err_q <= 1'b1;
  end

  // write-disable and lock
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (wr_en && is_ctl && !lock_q) begin
      wd_q   <= wdata[CTL_WD_BIT];
      lock_q <= wdata[CTL_LOCK_BIT];
    end
  end

  // syndrome inputs gathered from committed fuses
  always_comb begin
    for (int k = 0; k < RESP_WORDS; k++) resp_bits[k*WORD_W +: WORD_W] = fuse_q[RESP_IDX + k];
    for (int k = 0; k < KEY_WORDS; k++)  key_bits[k*WORD_W +: WORD_W]  = fuse_q[KEY_IDX + k];
  end

  fmc_syndrome #(.NBITS(RESP_BITS)) u_resp_syn (.bits(resp_bits), .syn(resp_syn));
  fmc_syndrome #(.NBITS(KEY_BITS))  u_key_syn  (.bits(key_bits),  .syn(key_syn));

  always_comb begin
    status = '0;
    status[RSW-1:0] = resp_syn;
    status[KEY_STAT_LSB +: KSW] = key_syn;
  end

  // read path
  always_comb begin
    rd_val = '0;
    if (is_cmd) begin
      rd_val[CMD_READ_BIT] = busy_read;
      rd_val[CMD_PROG_BIT] = busy_prog;
      rd_val[CMD_ERR_BIT]  = err_q;
    end else if (is_stat) begin
      rd_val = status;
    end else if (is_ctl) begin
      rd_val[CTL_WD_BIT]   = wd_q;
      rd_val[CTL_LOCK_BIT] = lock_q;
    end else if (is_fuse) begin
      rd_val = mirror_q[fidx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
    else            rdata <= '0;
  end
endmodule

// File: rtl/fmc_checker.sv
`timescale 1ns/1ps
module fmc_checker #(
  parameter int NW = 27
) (
  input logic        clk,
  input logic        rst,
  input logic        busy_prog,
  input logic        busy_read,
  input logic        err_q,
  input logic        wd_q,
  input logic        lock_q,
  input logic        prog_reject,
  input logic [31:0] fuse_q   [NW],
  input logic [31:0] mirror_q [NW]
);
  // R5: at most one operation runs at a time
  a_r5_one_op: assert property (@(posedge clk) disable iff (rst)
    $onehot0({busy_prog, busy_read}));

  // R8: a write-protected program request leaves the flag up and no burn running
  a_r8_wp_reject: assert property (@(posedge clk) disable iff (rst)
    prog_reject |=> (err_q && !busy_prog));

  // R10: lock holds itself and freezes write-disable
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lock_q)) |-> (lock_q && (wd_q == $past(wd_q))));

  for (genvar w = 0; w < NW; w++) begin : g_word
    // R12: fuse bits only rise
    a_r12_fuse_monotonic: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (($past(fuse_q[w]) & ~fuse_q[w]) == 32'h0));
    // R3: a mirror always covers the committed bits of its word
    a_r3_mirror_covers: assert property (@(posedge clk) disable iff (rst)
      (fuse_q[w] & ~mirror_q[w]) == 32'h0);
  end
endmodule

bind fuse_mirror_ctrl fmc_checker #(.NW(fmc_pkg::NWORDS)) u_fmc_checker (
  .clk(clk), .rst(rst), .busy_prog(busy_prog), .busy_read(busy_read),
  .err_q(err_q), .wd_q(wd_q), .lock_q(lock_q), .prog_reject(prog_reject),
  .fuse_q(fuse_q), .mirror_q(mirror_q)
);

// File: tb/test_fuse_mirror_ctrl.sv
`timescale 1ns/1ps
module test_fuse_mirror_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BURN = 3;
  localparam int NW = 27;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] stuck_mask = '0;
  logic [31:0] rdata;

  int vectors = 0;
  int fails = 0;
  bit chk_on = 1'b0;
  bit done = 1'b0;

  fuse_mirror_ctrl #(.BURN_CYCLES(BURN), .ADDR_W(12)) i_fuse_mirror_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .stuck_mask(stuck_mask), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] mf [NW];
  logic [31:0] mm [NW];
  logic [31:0] m_rdata = '0;
  logic [31:0] nb;
  int  mst = 0, mw = 0, mc = 0, wi;
  bit  merr = 0, mwd = 0, mlock = 0;

  function automatic int m_idx(logic [11:0] a);
    if (a[1:0] != 2'b00) return -1;
    if (a >= 12'h200 && a < 12'h218) return (int'(a) - 'h200) / 4;
    if (a >= 12'h234 && a < 12'h288) return 6 + (int'(a) - 'h234) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] m_status();
    int rx = 0, kx = 0;
    bit rp = 0, kp = 0;
    logic [31:0] s = '0;
    for (int b = 0; b < 64; b++)
      if (mf[4 + b/32][b%32]) begin rx = rx ^ b; rp = ~rp; end
    for (int b = 0; b < 256; b++)
      if (mf[6 + b/32][b%32]) begin kx = kx ^ b; kp = ~kp; end
    s[5:0]   = rx[5:0];
    s[6]     = rp;
    s[17:10] = kx[7:0];
    s[18]    = kp;
    return s;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a);
    logic [31:0] v = '0;
    int i = m_idx(a);
    if (a == 12'h020) begin v[8] = merr; v[1] = (mst == 1); v[0] = (mst == 2); end
    else if (a == 12'h024) v = m_status();
    else if (a == 12'h028) begin v[31] = mwd; v[30] = mlock; end
    else if (i >= 0) v = mm[i];
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW; i++) begin mf[i] = '0; mm[i] = '0; end
      m_rdata = '0; mst = 0; mw = 0; mc = 0; merr = 0; mwd = 0; mlock = 0;
    end else begin
      m_rdata = rd_en ? m_read(addr) : 32'h0;
      if (wr_en && addr == 12'h028 && !mlock) begin mwd = wdata[31]; mlock = wdata[30]; end
      if (mst == 1) begin
        if (mc == BURN - 1) begin
          nb = mf[mw] | (mm[mw] & ~stuck_mask);
          if (nb != mm[mw]) merr = 1;
          mf[mw] = nb;
          mc = 0;
          if (mw == NW - 1) mst = 0; else mw++;
        end else mc++;
      end else if (mst == 2) begin
        mm[mw] = mf[mw];
        if (mw == NW - 1) mst = 0; else mw++;
      end else if (wr_en) begin
        wi = m_idx(addr);
        if (addr == 12'h020) begin
          if (wdata[1]) begin
            if (mf[0][0]) merr = 1;
            else begin mst = 1; mw = 0; mc = 0; merr = 0; end
          end else if (wdata[0]) begin
            mst = 2; mw = 0; merr = 0;
          end
        end else if (wi >= 0 && !mwd) begin
          mm[wi] = mf[wi] | wdata;
        end
      end
    end
  end

  // every-clock comparison of the read port (R2)
  always @(negedge clk) begin
    if (chk_on && !done) begin
      vectors++;
      if (rdata !== m_rdata) begin
        fails++;
        $display("FAIL R2 model compare at %0t: actual %h expected %h", $time, rdata, m_rdata);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0; addr = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R4 watchdog: actual hung expected finished");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;

    // R1 reset state
    reg_rd(12'h020, v); check("R1 command", v, 32'h0);
    reg_rd(12'h028, v); check("R1 control", v, 32'h0);
    reg_rd(12'h024, v); check("R1 status", v, 32'h0);
    reg_rd(12'h274, v); check("R1 mirror", v, 32'h0);

    // R3 stage mirrors
    reg_wr(12'h204, 32'h0000_0005);
    reg_wr(12'h210, 32'h0000_0003);
    reg_wr(12'h214, 32'h0000_0001);
    reg_wr(12'h234, 32'h0000_0100);
    reg_wr(12'h238, 32'h0000_0001);
    reg_wr(12'h274, 32'h1234_5678);
    reg_rd(12'h274, v); check("R3 mirror readback", v, 32'h1234_5678);

    // R2 gap and idle read
    reg_rd(12'h230, v); check("R2 unmapped gap", v, 32'h0);
    @(negedge clk); check("R2 idle rdata", rdata, 32'h0);

    // R4 program
    reg_wr(12'h020, 32'h2);
    reg_rd(12'h020, v); check("R4 busy during program", v, 32'h2);
    idle(90);
    reg_rd(12'h020, v); check("R4 busy cleared", v, 32'h0);
    reg_rd(12'h024, v); check("R11 status after first burn", v, 32'h0000_A061);

    // R3 cannot clear programmed bit
    reg_wr(12'h234, 32'h0);
    reg_rd(12'h234, v); check("R3 programmed bit kept", v, 32'h0000_0100);
    reg_wr(12'h234, 32'h0001_0000);
    reg_rd(12'h234, v); check("R3 added bit", v, 32'h0001_0100);

    // R6 writes during busy
    reg_wr(12'h020, 32'h2);
    reg_wr(12'h238, 32'hFFFF_FFFF);
    reg_wr(12'h020, 32'h1);
    idle(90);
    reg_rd(12'h238, v); check("R6 mirror write ignored", v, 32'h0000_0001);
    reg_rd(12'h020, v); check("R6 command ignored", v, 32'h0);
    reg_rd(12'h024, v); check("R11 status after second burn", v, 32'h0004_E061);

    // R7 stuck cell raises error
    reg_wr(12'h278, 32'h0000_0011);
    stuck_mask = 32'h0000_0010;
    reg_wr(12'h020, 32'h2);
    idle(90);
    reg_rd(12'h020, v); check("R7 error flag", v, 32'h0000_0100);
    stuck_mask = 32'h0;

    // R5 read-back
    reg_wr(12'h27C, 32'h0000_0022);
    reg_wr(12'h020, 32'h1);
    reg_rd(12'h020, v); check("R5 read busy, R7 error cleared", v, 32'h1);
    idle(35);
    reg_rd(12'h278, v); check("R5 reloaded burned word", v, 32'h0000_0001);
    reg_rd(12'h27C, v); check("R5 unburned mirror reloaded", v, 32'h0);
    reg_rd(12'h234, v); check("R12 fuse bits retained", v, 32'h0001_0100);

    // R8 write protect (program wins over read, R5)
    reg_wr(12'h200, 32'h1);
    reg_wr(12'h020, 32'h3);
    reg_rd(12'h020, v); check("R5 program wins", v, 32'h2);
    idle(90);
    reg_rd(12'h200, v); check("R8 write protect blown", v, 32'h1);
    reg_wr(12'h20C, 32'h55);
    reg_rd(12'h20C, v); check("R3 staged challenge", v, 32'h55);
    reg_wr(12'h020, 32'h2);
    reg_rd(12'h020, v); check("R8 program rejected", v, 32'h0000_0100);
    reg_wr(12'h020, 32'h1);
    idle(35);
    reg_rd(12'h20C, v); check("R8 fuses unchanged", v, 32'h0);

    // R9 write-disable
    reg_wr(12'h028, 32'h8000_0000);
    reg_rd(12'h028, v); check("R9 disable readback", v, 32'h8000_0000);
    reg_wr(12'h280, 32'h7);
    reg_rd(12'h280, v); check("R9 mirror write blocked", v, 32'h0);
    reg_wr(12'h028, 32'h0);
    reg_wr(12'h280, 32'h7);
    reg_rd(12'h280, v); check("R9 write after enable", v, 32'h7);

    // R10 lock
    reg_wr(12'h028, 32'hC000_0000);
    reg_wr(12'h028, 32'h0);
    reg_rd(12'h028, v); check("R10 lock holds", v, 32'hC000_0000);
    reg_wr(12'h284, 32'h9);
    reg_rd(12'h284, v); check("R10 mirror still blocked", v, 32'h0);

    idle(2);
    finish_run();
  end
endmodule